// File: doc/BRIEF.md
# Processor Status Word with Context Save

This block is the status word of a small processor core: sixteen bits holding the arithmetic flags (carry, zero, sign, auxiliary carry, parity/overflow), the interrupt enable, a user flag, a register-set select bit and a three-bit register-bank select. Software sees the word one byte at a time, never as a whole word. Individual bits can be set, cleared or sampled by bit-manipulation operations. An ALU flag port with a per-flag enable mask lets each instruction touch only the flags it defines.

The word saves and restores itself along two separate paths. A vectored interrupt or a break sends the word to a stack port. A context switch sends it to a register-pair port. Each save path is a valid/ready output slot. The slot captures the word on a save strobe and holds it until the consumer takes it. Each restore path is a valid/ready input that is always ready outside reset, so a restore completes in the cycle it is offered. On an interrupt save the interrupt enable is cleared once the old value has been captured.

Bit layout. Low byte: 7 S, 6 Z, 5 RSS, 4 AC, 3 IE, 2 P/V, 1 reserved, 0 CY. High byte: 7 UF, 6..4 bank select, 3..0 reserved. The bit index on the bit port is the position in the 16-bit word, with the high byte at 15..8. The bit-operation code is 0 none, 1 set, 2 clear, 3 none.

Top module: `status_word`

## Requirements
- R1: Reset clears all sixteen bits and drops both save outputs' valid.
- R2: A byte write replaces only the byte chosen by the high/low select (1 = high byte) and leaves the other byte unchanged.
- R3: The read port returns the byte chosen by the read select (1 = high byte) combinationally from the current word.
- R4: A bit operation with code 1 sets, and code 2 clears, only the bit at the given index. The bit-test output always shows the current value of the indexed bit.
- R5: An ALU update loads, from the ALU value, only the low-byte bits whose mask bit is 1. All other bits keep their value.
- R6: Within one cycle the sources are applied in strict priority, highest first: restore, byte write, bit operation, ALU update. Only the highest active source takes effect.
- R7: An interrupt save that the stack slot accepts places the word as it was before that edge on the stack output and leaves IE at 0. A break save carries the word the same way but leaves IE unchanged.
- R8: A context-switch save goes only to the register-pair output and carries the current word. It does not alter the word.
- R9: A save output keeps valid high and its data stable until ready is sampled high. A save request to a slot that is still holding unaccepted data is ignored: no new capture and no IE clear.
- R10: An offered restore loads the whole word in one cycle. The stack restore wins over the register-pair restore when both are valid. Both restore readies are high whenever reset is not asserted.
- R11: Reserved bits (high byte 3..0, low byte bit 1) read 0 whatever is written, set or restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_hi | input | 1 | Read byte select, 1 = high byte |
| rd_data | output | 8 | Selected byte of the word |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | Write byte select, 1 = high byte |
| wr_data | input | 8 | Byte write data |
| bit_op | input | 2 | Bit operation: 0 none, 1 set, 2 clear |
| bit_idx | input | 4 | Bit position in the word |
| bit_val | output | 1 | Current value of the indexed bit |
| alu_mask | input | 8 | Per-flag enable for the low byte |
| alu_val | input | 8 | Flag values from the ALU |
| save_irq | input | 1 | Vectored interrupt save request |
| save_brk | input | 1 | Break save request |
| save_cs | input | 1 | Context-switch save request |
| stk_o_valid | output | 1 | Stack save data valid |
| stk_o_ready | input | 1 | Stack consumer ready |
| stk_o_data | output | 16 | Saved word toward the stack |
| rp_o_valid | output | 1 | Register-pair save data valid |
| rp_o_ready | input | 1 | Register-pair consumer ready |
| rp_o_data | output | 16 | Saved word toward the register pair |
| stk_i_valid | input | 1 | Restore from stack offered |
| stk_i_ready | output | 1 | Stack restore accepted |
| stk_i_data | input | 16 | Word restored from the stack |
| rp_i_valid | input | 1 | Restore from register pair offered |
| rp_i_ready | output | 1 | Register-pair restore accepted |
| rp_i_data | input | 16 | Word restored from the register pair |
| flag_cy | output | 1 | Carry flag |
| flag_ie | output | 1 | Interrupt enable |
| bank_sel | output | 3 | Register-bank select |

## Verification
The assertions check on every cycle that the reserved bits stay zero and that a pending save output holds valid and its data. They also check that an accepted interrupt save captures the prior word and leaves IE clear, that a context save reaches only the register-pair output, that a restore loads the word, and that an ALU update touches only masked flags. The bench scenarios are needed for behaviour that no single-cycle property captures in full. This covers the ordering when several sources collide in one cycle, byte isolation on writes and reads, bit-test readback, the ignored save request while a slot is full, the break save keeping IE, and the return to zero on a reset in the middle of a run.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(WORD_W);

  // bit positions decoded by neighbouring logic
  localparam int B_CY  = 0;
  localparam int B_PV  = 2;
  localparam int B_IE  = 3;
  localparam int B_AC  = 4;
  localparam int B_RSS = 5;
  localparam int B_Z   = 6;
  localparam int B_S   = 7;
  localparam int B_BANK_LO = 12;
  localparam int BANK_W    = 3;
  localparam int B_UF  = 15;

  localparam logic [WORD_W-1:0] RSV_MASK = 16'h0F02;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_RSVD = 2'd3
  } bop_e;
endpackage

// File: rtl/psw_next.sv
`timescale 1ns/1ps
module psw_next
  import psw_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESERVED = RSV_MASK
) (
  input  logic [WORD_W-1:0] cur,
  input  logic              stk_in_v,
  input  logic [WORD_W-1:0] stk_in_d,
  input  logic              rp_in_v,
  input  logic [WORD_W-1:0] rp_in_d,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  bop_e              bop,
  input  logic [IDX_W-1:0]  bidx,
  input  logic [BYTE_W-1:0] amask,
  input  logic [BYTE_W-1:0] aval,
  input  logic              ie_clr,
  output logic [WORD_W-1:0] nxt
);
  logic [WORD_W-1:0] sel;

  // priority: restore, byte write, bit op, ALU
  always_comb begin
    sel = cur;
    if (stk_in_v) begin
      sel = stk_in_d;
    end else if (rp_in_v) begin
      sel = rp_in_d;
    end else if (wr_en) begin
      if (wr_hi) sel[WORD_W-1:BYTE_W] = wr_data;
      else       sel[BYTE_W-1:0]      = wr_data;
    end else if (bop == BOP_SET) begin
      sel[bidx] = 1'b1;
    end else if (bop == BOP_CLR) begin
      sel[bidx] = 1'b0;
    end else if (amask != '0) begin
      sel[BYTE_W-1:0] = (cur[BYTE_W-1:0] & ~amask) | (aval & amask);
    end
  end

  always_comb begin
    nxt = sel;
    if (ie_clr) nxt[B_IE] = 1'b0;
    nxt = nxt & ~RESERVED;
  end
endmodule

// File: rtl/psw_save_slot.sv
`timescale 1ns/1ps
module psw_save_slot
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [WORD_W-1:0] word,
  output logic              accept,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [WORD_W-1:0] o_data
);
  assign accept = cap && (!o_valid || o_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (accept) begin
      o_valid <= 1'b1;
      o_data  <= word;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
endmodule

// File: rtl/status_word.sv
`timescale 1ns/1ps
module status_word
  import psw_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESERVED = RSV_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_hi,
  output logic [BYTE_W-1:0]    rd_data,
  input  logic                 wr_en,
  input  logic                 wr_hi,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [1:0]           bit_op,
  input  logic [IDX_W-1:0]     bit_idx,
  output logic                 bit_val,
  input  logic [BYTE_W-1:0]    alu_mask,
  input  logic [BYTE_W-1:0]    alu_val,
  input  logic                 save_irq,
  input  logic                 save_brk,
  input  logic                 save_cs,
  output logic                 stk_o_valid,
  input  logic                 stk_o_ready,
  output logic [WORD_W-1:0]    stk_o_data,
  output logic                 rp_o_valid,
  input  logic                 rp_o_ready,
  output logic [WORD_W-1:0]    rp_o_data,
  input  logic                 stk_i_valid,
  output logic                 stk_i_ready,
  input  logic [WORD_W-1:0]    stk_i_data,
  input  logic                 rp_i_valid,
  output logic                 rp_i_ready,
  input  logic [WORD_W-1:0]    rp_i_data,
  output logic                 flag_cy,
  output logic                 flag_ie,
  output logic [BANK_W-1:0]    bank_sel
);
  logic [WORD_W-1:0] word_q, word_d;
  logic stk_acc, rp_acc, ie_clr;

  psw_save_slot u_stk_slot (
    .clk(clk), .rst_n(rst_n), .cap(save_irq || save_brk), .word(word_q),
    .accept(stk_acc), .o_valid(stk_o_valid), .o_ready(stk_o_ready), .o_data(stk_o_data)
  );

  psw_save_slot u_rp_slot (
    .clk(clk), .rst_n(rst_n), .cap(save_cs), .word(word_q),
    .accept(rp_acc), .o_valid(rp_o_valid), .o_ready(rp_o_ready), .o_data(rp_o_data)
  );

  assign ie_clr = save_irq && stk_acc;

  psw_next #(.RESERVED(RESERVED)) u_next (
    .cur(word_q),
    .stk_in_v(stk_i_valid), .stk_in_d(stk_i_data),
    .rp_in_v(rp_i_valid),   .rp_in_d(rp_i_data),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .bop(bop_e'(bit_op)), .bidx(bit_idx),
    .amask(alu_mask), .aval(alu_val),
    .ie_clr(ie_clr), .nxt(word_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign stk_i_ready = rst_n;
  assign rp_i_ready  = rst_n;
  assign rd_data  = rd_hi ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
  assign bit_val  = word_q[bit_idx];
  assign flag_cy  = word_q[B_CY];
  assign flag_ie  = word_q[B_IE];
  assign bank_sel = word_q[B_BANK_LO +: BANK_W];

  assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q & RESERVED) == '0);

  assert_irq_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (save_irq && stk_acc) |=> (!flag_ie && stk_o_valid && stk_o_data == $past(word_q)));

  assert_cs_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (save_cs && rp_acc) |=> (rp_o_valid && rp_o_data == $past(word_q)));

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_i_valid && !save_irq) |=> (word_q == ($past(stk_i_data) & ~RESERVED)));

  assert_alu_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_i_valid && !rp_i_valid && !wr_en && !bit_op[0] && !bit_op[1] && !save_irq)
      |=> ((word_q & ~{8'h00, $past(alu_mask)}) == ($past(word_q) & ~{8'h00, $past(alu_mask)})));
endmodule

// File: tb/sim_status_word.sv
`timescale 1ns/1ps
module sim_status_word;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rd_hi, wr_en, wr_hi, bit_val;
  logic [7:0] rd_data, wr_data, alu_mask, alu_val;
  logic [1:0] bit_op;
  logic [3:0] bit_idx;
  logic save_irq, save_brk, save_cs;
  logic stk_o_valid, stk_o_ready, rp_o_valid, rp_o_ready;
  logic [15:0] stk_o_data, rp_o_data, stk_i_data, rp_i_data;
  logic stk_i_valid, stk_i_ready, rp_i_valid, rp_i_ready;
  logic flag_cy, flag_ie;
  logic [2:0] bank_sel;

  int checks = 0;
  int fails = 0;

  status_word u0 (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr_en = 0; bit_op = 0; alu_mask = 0; save_irq = 0; save_brk = 0; save_cs = 0;
    stk_i_valid = 0; rp_i_valid = 0;
  endtask

  task automatic get_word(output logic [15:0] w);
    rd_hi = 1; #0.2; w[15:8] = rd_data;
    rd_hi = 0; #0.2; w[7:0] = rd_data;
  endtask

  task automatic wbyte(input logic hi, input logic [7:0] d);
    wr_en = 1; wr_hi = hi; wr_data = d; step(); idle();
  endtask

  task automatic t_reset();
    logic [15:0] w;
    wbyte(0, 8'hFF); wbyte(1, 8'hFF);
    rst_n = 0; step(); step(); rst_n = 1;
    get_word(w);
    chk("R1 word", w, 16'h0000);
    chk("R1 valids", {stk_o_valid, rp_o_valid}, 0);
  endtask

  task automatic t_bytes();
    logic [15:0] w;
    wbyte(0, 8'hFF);
    get_word(w); chk("R2/R11 low write", w, 16'h00FD);
    wbyte(1, 8'hA5);
    get_word(w); chk("R2/R11 high write", w, 16'hA0FD);
    rd_hi = 1; #0.2; chk("R3 read high", rd_data, 8'hA0);
    rd_hi = 0; #0.2; chk("R3 read low", rd_data, 8'hFD);
    chk("R3 bank", bank_sel, 3'd2);
  endtask

  task automatic t_bits();
    logic [15:0] w;
    wbyte(0, 8'h00); wbyte(1, 8'h00);
    bit_op = 1; bit_idx = 0; step(); idle();
    get_word(w); chk("R4 set bit0", w, 16'h0001);
    chk("R4 test bit0", bit_val, 1'b1);
    bit_op = 1; bit_idx = 1; step(); idle();
    get_word(w); chk("R4/R11 set reserved", w, 16'h0001);
    bit_op = 1; bit_idx = 15; step(); idle();
    bit_op = 2; bit_idx = 0; step(); idle();
    get_word(w); chk("R4 set15 clear0", w, 16'h8000);
    bit_idx = 15; #0.2; chk("R4 test bit15", bit_val, 1'b1);
  endtask

  task automatic t_alu();
    logic [15:0] w;
    wbyte(0, 8'h00);
    alu_mask = 8'h41; alu_val = 8'hFF; step(); idle();
    get_word(w); chk("R5 masked set", w[7:0], 8'h41);
    alu_mask = 8'h01; alu_val = 8'h00; step(); idle();
    get_word(w); chk("R5 mask cy only", w[7:0], 8'h40);
    chk("R5 cy pin", flag_cy, 1'b0);
  endtask

  task automatic t_prio();
    logic [15:0] w;
    wbyte(0, 8'h00); wbyte(1, 8'h00);
    wr_en = 1; wr_hi = 0; wr_data = 8'h80; bit_op = 1; bit_idx = 0;
    alu_mask = 8'h40; alu_val = 8'h40; step(); idle();
    get_word(w); chk("R6 write wins", w, 16'h0080);
    bit_op = 1; bit_idx = 6; alu_mask = 8'h01; alu_val = 8'h01; step(); idle();
    get_word(w); chk("R6 bit op over alu", w, 16'h00C0);
    stk_i_valid = 1; stk_i_data = 16'h1234; rp_i_valid = 1; rp_i_data = 16'h7055;
    wr_en = 1; wr_hi = 1; wr_data = 8'hFF;
    #0.2; chk("R10 readies", {stk_i_ready, rp_i_ready}, 2'b11);
    step(); idle();
    get_word(w); chk("R6/R10 stack restore wins", w, 16'h1034);
  endtask

  task automatic t_irq();
    logic [15:0] w;
    wbyte(0, 8'h08); wbyte(1, 8'h10);
    stk_o_ready = 0; save_irq = 1; step(); idle();
    get_word(w);
    chk("R7 ie cleared", w, 16'h1000);
    chk("R7 stack valid", stk_o_valid, 1'b1);
    chk("R7 stack image", stk_o_data, 16'h1008);
    wbyte(0, 8'h09);
    save_brk = 1; step(); idle(); step();
    chk("R9 held data", stk_o_data, 16'h1008);
    chk("R9 held valid", stk_o_valid, 1'b1);
    wbyte(0, 8'h08);
    save_irq = 1; step(); idle();
    chk("R9 ignored irq keeps ie", flag_ie, 1'b1);
    stk_o_ready = 1; step();
    chk("R9 drained", stk_o_valid, 1'b0);
  endtask

  task automatic t_brk();
    stk_o_ready = 0; save_brk = 1; step(); idle();
    chk("R7 brk keeps ie", flag_ie, 1'b1);
    chk("R7 brk image", stk_o_data, 16'h1008);
    stk_o_ready = 1; step();
    chk("R7 brk drained", stk_o_valid, 1'b0);
  endtask

  task automatic t_cs();
    logic [15:0] w;
    wbyte(0, 8'h8D);
    rp_o_ready = 0; save_cs = 1; step(); idle();
    get_word(w);
    chk("R8 word kept", w, 16'h108D);
    chk("R8 rp image", rp_o_data, 16'h108D);
    chk("R8 paths", {rp_o_valid, stk_o_valid}, 2'b10);
    rp_o_ready = 1; step();
    rp_i_valid = 1; rp_i_data = 16'hFFFF; step(); idle();
    get_word(w); chk("R10/R11 rp restore", w, 16'hF0FD);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rd_hi = 0; wr_hi = 0; wr_data = 0; bit_idx = 0; alu_val = 0;
    stk_i_data = 0; rp_i_data = 0; stk_o_ready = 1; rp_o_ready = 1;
    idle();
    step(); step(); rst_n = 1; step();
    t_reset();
    t_bytes();
    t_bits();
    t_alu();
    t_prio();
    t_irq();
    t_brk();
    t_cs();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule